// File: doc/BRIEF.md
# Program Sequencer with Scalar ALU

This block is the in-order controller of a processing cell. It reads one 32-bit instruction word per cycle from a local instruction memory and executes control instructions itself. Those are stop, stall for a fixed number of cycles or until an event, drive a port activation mask, compute on a 16-entry scalar register file and a 16-entry flag file, and take a two-way relative branch. Every word whose top bit is set is a resource instruction. The sequencer does not interpret it. It places the word on a dispatch bus for one cycle, tagged with its slot index.

The instruction memory is read combinationally: `imem_addr` is the program counter, and `imem_data` must return that word in the same cycle. Each dispatch or activation pulse appears in the cycle after the instruction was fetched. The sequencer never waits on the receiver of a pulse.

The controller has four states. RUN fetches and executes one word per cycle. CYCLE_WAIT counts down a timed stall. EVENT_WAIT stalls until a selected event input is high. HALT is final until reset. The transitions are:
- RUN to HALT on a stop word.
- RUN to CYCLE_WAIT on a timed wait with a nonzero count.
- RUN to EVENT_WAIT on an event wait.
- CYCLE_WAIT to RUN when the count expires.
- EVENT_WAIT to RUN on the first cycle in which a masked event input is high.
- Every other case stays in its current state.

Top module: `ctl_sequencer`

## Requirements
- R1: While reset is low, `imem_addr` is 0 and `disp_valid`, `act_valid` and `halted` are 0. All scalar and flag registers clear to 0.
- R2: Bit 31 selects the class (1 = resource), and bits 30:28 hold the opcode. A resource word raises `disp_valid` for exactly one cycle, in the cycle after its fetch. The pulse carries `disp_slot` = bits 27:24 and `disp_word` = the whole word. The next address follows at once, so back-to-back resource words pulse on consecutive cycles.
- R3: Control opcode 0 (stop) enters HALT. In HALT, `halted` is 1, `imem_addr` is frozen, and no pulse is produced.
- R4: Control opcode 1 with bit 27 = 0 is a timed wait on the count N in bits 26:0. It occupies its issue cycle plus N further cycles. During that time nothing is fetched or pulsed, so two resource words around it pulse N+2 cycles apart.
- R5: Control opcode 1 with bit 27 = 1 is an event wait on the mask in bits 26:0. It ends in the first cycle in which `evt_in & mask` is nonzero, and the next word is fetched in the following cycle. Event inputs outside the mask have no effect.
- R6: Control opcode 2 (activate) has a 16-bit slot mask in bits 27:12, a mode in bits 11:8 and a parameter in bits 7:0. Mode 0 pulses `act_valid` for one cycle with `act_mask` = slot mask shifted left by the parameter. Bits shifted past the top are lost.
- R7: In activate mode 1, `act_mask` bit s*PPS+p is set when slot s is set in the mask and p equals the parameter. A parameter of PPS or more gives an all-zero mask, still with a pulse.
- R8: An activate word with a mode other than 0 or 1 produces no pulse.
- R9: Control opcode 3 (calc) has its mode in bits 27:22, operand A register in 21:18, a select bit at 17, operand B in 16:9 and the destination in 8:5. With the select bit at 0, operand B is the zero-extended 8-bit value. With it at 1, operand B is the scalar register, or for flag modes the flag register, named by bits 12:9.
- R10: Calc modes 1 add, 2 sub, 3 shift left, 4 shift right (logical), 5 mul, 8 and, 9 or, 10 invert A, 11 xor write the scalar destination, modulo 2^DATA_W.
- R11: Modes 17 to 22 (eq, ne, gt, ge, lt, le) compare scalars unsigned and write the flag destination. Modes 32, 33 and 34 (logical and, or, not of A) act on flags and write the flag destination. With the select bit at 0, the flag operand B is bit 0 of the value.
- R12: Any other calc mode changes no register.
- R13: Control opcode 4 (branch) reads the flag in bits 27:24. The next address is the branch's own address plus the signed 9-bit offset in bits 23:15 when the flag is 1, or the offset in bits 14:6 when it is 0, wrapping modulo 2^PC_W.
- R14: Control opcodes 5 to 7 do nothing and advance the address by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | PC_W | Program counter / instruction memory address |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| evt_in | input | 27 | Event inputs for event waits |
| disp_valid | output | 1 | One-cycle strobe for a resource word |
| disp_slot | output | 4 | Slot index of the dispatched word |
| disp_word | output | 32 | Dispatched resource word |
| act_valid | output | 1 | One-cycle strobe for an activation |
| act_mask | output | 16*PPS | Slot-by-port activation mask |
| halted | output | 1 | High in HALT |

## Verification
The checker takes for granted that `imem_data` returns the word at `imem_addr` within the same cycle. It also assumes that any event wait the program issues carries a nonzero mask, since a zero mask parks the controller for good. The bench models the memory as a combinational array indexed by the address, so the first assumption always holds. Every event wait in its program selects exactly one input. The bench drives `evt_in` only on falling edges, so the countdown and event-hold properties see settled inputs.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    localparam int INSTR_W = 32;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_CYC,
        ST_EVT,
        ST_HALT
    } seq_state_t;

    localparam logic [2:0] OP_HALT = 3'd0;
    localparam logic [2:0] OP_WAIT = 3'd1;
    localparam logic [2:0] OP_ACT  = 3'd2;
    localparam logic [2:0] OP_CALC = 3'd3;
    localparam logic [2:0] OP_BRN  = 3'd4;

    localparam logic [5:0] CM_ADD  = 6'd1;
    localparam logic [5:0] CM_SUB  = 6'd2;
    localparam logic [5:0] CM_SHL  = 6'd3;
    localparam logic [5:0] CM_SHR  = 6'd4;
    localparam logic [5:0] CM_MUL  = 6'd5;
    localparam logic [5:0] CM_AND  = 6'd8;
    localparam logic [5:0] CM_OR   = 6'd9;
    localparam logic [5:0] CM_INV  = 6'd10;
    localparam logic [5:0] CM_XOR  = 6'd11;
    localparam logic [5:0] CM_EQ   = 6'd17;
    localparam logic [5:0] CM_NE   = 6'd18;
    localparam logic [5:0] CM_GT   = 6'd19;
    localparam logic [5:0] CM_GE   = 6'd20;
    localparam logic [5:0] CM_LT   = 6'd21;
    localparam logic [5:0] CM_LE   = 6'd22;
    localparam logic [5:0] CM_LAND = 6'd32;
    localparam logic [5:0] CM_LOR  = 6'd33;
    localparam logic [5:0] CM_LNOT = 6'd34;

endpackage

// File: rtl/seqr_regs.sv
module seqr_regs #(
    parameter int NREG   = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_we,
    input  logic [IDX_W-1:0]  s_wa,
    input  logic [DATA_W-1:0] s_wd,
    input  logic              f_we,
    input  logic [IDX_W-1:0]  f_wa,
    input  logic              f_wd,
    input  logic [IDX_W-1:0]  s_ra,
    input  logic [IDX_W-1:0]  s_rb,
    input  logic [IDX_W-1:0]  f_ra,
    input  logic [IDX_W-1:0]  f_rb,
    input  logic [IDX_W-1:0]  f_rc,
    output logic [DATA_W-1:0] s_a,
    output logic [DATA_W-1:0] s_b,
    output logic              f_a,
    output logic              f_b,
    output logic              f_c
);

    logic [NREG-1:0][DATA_W-1:0] sregs;
    logic [NREG-1:0]             flags;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sregs <= '0;
            flags <= '0;
        end else begin
            if (s_we) sregs[s_wa] <= s_wd;
            if (f_we) flags[f_wa] <= f_wd;
        end
    end

    assign s_a = sregs[s_ra];
    assign s_b = sregs[s_rb];
    assign f_a = flags[f_ra];
    assign f_b = flags[f_rb];
    assign f_c = flags[f_rc];

endmodule

// File: rtl/seqr_alu.sv
module seqr_alu
    import seqr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [5:0]        mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              fa,
    input  logic              fb,
    output logic [DATA_W-1:0] s_res,
    output logic              s_we,
    output logic              f_res,
    output logic              f_we
);

    always_comb begin
        s_res = '0;
        s_we  = 1'b0;
        f_res = 1'b0;
        f_we  = 1'b0;
        case (mode)
            CM_ADD:  begin s_res = a + b;  s_we = 1'b1; end
            CM_SUB:  begin s_res = a - b;  s_we = 1'b1; end
            CM_SHL:  begin s_res = a << b; s_we = 1'b1; end
            CM_SHR:  begin s_res = a >> b; s_we = 1'b1; end
            CM_MUL:  begin s_res = a * b;  s_we = 1'b1; end
            CM_AND:  begin s_res = a & b;  s_we = 1'b1; end
            CM_OR:   begin s_res = a | b;  s_we = 1'b1; end
            CM_INV:  begin s_res = ~a;     s_we = 1'b1; end
            CM_XOR:  begin s_res = a ^ b;  s_we = 1'b1; end
            CM_EQ:   begin f_res = (a == b); f_we = 1'b1; end
            CM_NE:   begin f_res = (a != b); f_we = 1'b1; end
            CM_GT:   begin f_res = (a >  b); f_we = 1'b1; end
            CM_GE:   begin f_res = (a >= b); f_we = 1'b1; end
            CM_LT:   begin f_res = (a <  b); f_we = 1'b1; end
            CM_LE:   begin f_res = (a <= b); f_we = 1'b1; end
            CM_LAND: begin f_res = fa && fb; f_we = 1'b1; end
            CM_LOR:  begin f_res = fa || fb; f_we = 1'b1; end
            CM_LNOT: begin f_res = !fa;      f_we = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/seqr_actmap.sv
module seqr_actmap #(
    parameter int NSLOT = 16,
    parameter int PPS   = 4,
    localparam int MASK_W = NSLOT * PPS
) (
    input  logic [NSLOT-1:0]  slots,
    input  logic [3:0]        mode,
    input  logic [7:0]        param,
    output logic              ok,
    output logic [MASK_W-1:0] mask
);

    logic [MASK_W-1:0] span_mask;
    logic [MASK_W-1:0] port_mask;

    assign span_mask = MASK_W'(slots) << param;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        for (genvar p = 0; p < PPS; p++) begin : g_port
            assign port_mask[s*PPS + p] = slots[s] && (param == 8'(p));
        end
    end

    always_comb begin
        ok   = 1'b0;
        mask = '0;
        case (mode)
            4'd0: begin ok = 1'b1; mask = span_mask; end
            4'd1: begin ok = 1'b1; mask = port_mask; end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
    import seqr_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int DATA_W = 16,
    parameter int PPS    = 4,
    localparam int MASK_W = 16 * PPS,
    localparam int EVT_W  = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [31:0]       imem_data,
    input  logic [EVT_W-1:0]  evt_in,
    output logic              disp_valid,
    output logic [3:0]        disp_slot,
    output logic [31:0]       disp_word,
    output logic              act_valid,
    output logic [MASK_W-1:0] act_mask,
    output logic              halted
);

    localparam int NREG = 16;
    localparam int OFF_W = 9;

    seq_state_t      state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic [EVT_W-1:0] wcnt_q, wcnt_d;
    logic [EVT_W-1:0] emask_q, emask_d;

    // field decode
    logic       is_res;
    logic [2:0] opc;
    logic       run_now, ctl_go;
    logic       wait_evt;
    logic [EVT_W-1:0] wait_arg;
    logic [5:0] c_mode;
    logic [3:0] c_ra, c_rd;
    logic       c_sel;
    logic [7:0] c_opb;
    logic [3:0] b_flag;
    logic signed [OFF_W-1:0] b_true, b_false, b_off;

    assign is_res   = imem_data[31];
    assign opc      = imem_data[30:28];
    assign run_now  = (state_q == ST_RUN);
    assign ctl_go   = run_now && !is_res;
    assign wait_evt = imem_data[27];
    assign wait_arg = imem_data[26:0];
    assign c_mode   = imem_data[27:22];
    assign c_ra     = imem_data[21:18];
    assign c_sel    = imem_data[17];
    assign c_opb    = imem_data[16:9];
    assign c_rd     = imem_data[8:5];
    assign b_flag   = imem_data[27:24];
    assign b_true   = imem_data[23:15];
    assign b_false  = imem_data[14:6];

    // register files and ALU
    logic [DATA_W-1:0] s_a, s_b, alu_b, alu_s;
    logic f_a, f_b, f_c, alu_fb, alu_f;
    logic alu_swe, alu_fwe, calc_go;

    assign calc_go = ctl_go && (opc == OP_CALC);
    assign alu_b   = c_sel ? s_b : DATA_W'(c_opb);
    assign alu_fb  = c_sel ? f_b : c_opb[0];

    seqr_regs #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .s_we (calc_go && alu_swe),
        .s_wa (c_rd),
        .s_wd (alu_s),
        .f_we (calc_go && alu_fwe),
        .f_wa (c_rd),
        .f_wd (alu_f),
        .s_ra (c_ra),
        .s_rb (c_opb[3:0]),
        .f_ra (c_ra),
        .f_rb (c_opb[3:0]),
        .f_rc (b_flag),
        .s_a  (s_a),
        .s_b  (s_b),
        .f_a  (f_a),
        .f_b  (f_b),
        .f_c  (f_c)
    );

    seqr_alu #(.DATA_W(DATA_W)) u_alu (
        .mode (c_mode),
        .a    (s_a),
        .b    (alu_b),
        .fa   (f_a),
        .fb   (alu_fb),
        .s_res(alu_s),
        .s_we (alu_swe),
        .f_res(alu_f),
        .f_we (alu_fwe)
    );

    // activation map
    logic              act_ok;
    logic [MASK_W-1:0] act_map;

    seqr_actmap #(.NSLOT(16), .PPS(PPS)) u_act (
        .slots(imem_data[27:12]),
        .mode (imem_data[11:8]),
        .param(imem_data[7:0]),
        .ok   (act_ok),
        .mask (act_map)
    );

    assign b_off = f_c ? b_true : b_false;

    // next state
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        wcnt_d  = wcnt_q;
        emask_d = emask_q;
        unique case (state_q)
            ST_RUN: begin
                if (is_res) begin
                    pc_d = pc_q + PC_W'(1);
                end else begin
                    case (opc)
                        OP_HALT: state_d = ST_HALT;
                        OP_WAIT: begin
                            pc_d = pc_q + PC_W'(1);
                            if (wait_evt) begin
                                emask_d = wait_arg;
                                state_d = ST_EVT;
                            end else if (wait_arg != '0) begin
                                wcnt_d  = wait_arg;
                                state_d = ST_CYC;
                            end
                        end
                        OP_BRN:  pc_d = pc_q + PC_W'(b_off);
                        default: pc_d = pc_q + PC_W'(1);
                    endcase
                end
            end
            ST_CYC: begin
                if (wcnt_q == EVT_W'(1)) state_d = ST_RUN;
                else                     wcnt_d  = wcnt_q - EVT_W'(1);
            end
            ST_EVT: begin
                if ((evt_in & emask_q) != '0) state_d = ST_RUN;
            end
            ST_HALT: ;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
            wcnt_q  <= '0;
            emask_q <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            wcnt_q  <= wcnt_d;
            emask_q <= emask_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_valid <= 1'b0;
            disp_slot  <= '0;
            disp_word  <= '0;
            act_valid  <= 1'b0;
            act_mask   <= '0;
        end else begin
            disp_valid <= run_now && is_res;
            disp_slot  <= imem_data[27:24];
            disp_word  <= imem_data;
            act_valid  <= ctl_go && (opc == OP_ACT) && act_ok;
            act_mask   <= act_map;
        end
    end

    assign imem_addr = pc_q;
    assign halted    = (state_q == ST_HALT);

endmodule

// File: rtl/seqr_chk.sv
module seqr_chk
    import seqr_pkg::*;
#(
    parameter int PC_W  = 8,
    parameter int EVT_W = 27
) (
    input logic             clk,
    input logic             rst_n,
    input seq_state_t       state_q,
    input logic [EVT_W-1:0] wcnt_q,
    input logic [EVT_W-1:0] emask_q,
    input logic [EVT_W-1:0] evt_in,
    input logic [PC_W-1:0]  imem_addr,
    input logic             disp_valid,
    input logic [3:0]       disp_slot,
    input logic [31:0]      disp_word,
    input logic             act_valid,
    input logic             halted
);

    // R2
    slot_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_slot == disp_word[27:24]) && disp_word[31]);

    // R3
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(imem_addr));

    // R3
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !disp_valid && !act_valid);

    // R4
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> !disp_valid && !act_valid);

    // R4
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CYC && wcnt_q != EVT_W'(1)) |=>
            (state_q == ST_CYC) && (wcnt_q == $past(wcnt_q) - EVT_W'(1)));

    // R5
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVT && (evt_in & emask_q) == '0) |=> (state_q == ST_EVT));

    // R5
    evt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVT && (evt_in & emask_q) != '0) |=> (state_q == ST_RUN));

endmodule

bind ctl_sequencer seqr_chk #(.PC_W(PC_W), .EVT_W(EVT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .wcnt_q    (wcnt_q),
    .emask_q   (emask_q),
    .evt_in    (evt_in),
    .imem_addr (imem_addr),
    .disp_valid(disp_valid),
    .disp_slot (disp_slot),
    .disp_word (disp_word),
    .act_valid (act_valid),
    .halted    (halted)
);

// File: tb/sim_ctl_sequencer.sv
`timescale 1ns/1ps
module sim_ctl_sequencer;

    localparam int PC_W   = 8;
    localparam int MASK_W = 64;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic [PC_W-1:0]   imem_addr;
    logic [31:0]       imem_data;
    logic [26:0]       evt_in;
    logic              disp_valid;
    logic [3:0]        disp_slot;
    logic [31:0]       disp_word;
    logic              act_valid;
    logic [MASK_W-1:0] act_mask;
    logic              halted;

    logic [31:0] mem [256];
    assign imem_data = mem[imem_addr];

    ctl_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .evt_in(evt_in), .disp_valid(disp_valid), .disp_slot(disp_slot),
        .disp_word(disp_word), .act_valid(act_valid), .act_mask(act_mask),
        .halted(halted)
    );

    typedef struct {
        bit          kind;
        logic [3:0]  slot;
        logic [63:0] data;
        int          gap;
        string       req;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_fail = 0, wp = 0, tagc = 0;
    int cyc = 0, last_cyc = 0, n_pulse = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] w_res(int s, int t);
        return {1'b1, 3'd6, 4'(s), 24'(t)};
    endfunction
    function automatic logic [31:0] w_wait(bit ev, int n);
        return {1'b0, 3'd1, ev, 27'(n)};
    endfunction
    function automatic logic [31:0] w_act(int ports, int m, int p);
        return {1'b0, 3'd2, 16'(ports), 4'(m), 8'(p)};
    endfunction
    function automatic logic [31:0] w_calc(int m, int a, bit sd, int b, int d);
        return {1'b0, 3'd3, 6'(m), 4'(a), sd, 8'(b), 4'(d), 5'd0};
    endfunction
    function automatic logic [31:0] w_brn(int f, int t, int e);
        return {1'b0, 3'd4, 4'(f), 9'(t), 9'(e), 6'd0};
    endfunction

    function automatic void put(logic [31:0] w);
        mem[wp] = w;
        wp++;
    endfunction

    // driver: emits a resource word and queues its expected pulse
    function automatic void emit_res(int s, int t, int gap, string req);
        put(w_res(s, t));
        q.push_back('{1'b0, 4'(s), 64'(w_res(s, t)), gap, req});
    endfunction

    function automatic void emit_act(int ports, int m, int p, logic [63:0] exp_mask, string req);
        put(w_act(ports, m, p));
        q.push_back('{1'b1, 4'd0, exp_mask, 1, req});
    endfunction

    // branch on flag f; the pass marker is reached only if the flag equals want
    function automatic void chk_flag(int f, bit want, string req);
        tagc++;
        if (want) put(w_brn(f, 2, 1));
        else      put(w_brn(f, 1, 2));
        put(w_res(2, 24'hBAD000 + tagc));
        emit_res(1, tagc, -1, req);
    endfunction

    function automatic void chk_reg(int r, int v, string req);
        put(w_calc(17, r, 1'b0, v, 0));
        chk_flag(0, 1'b1, req);
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each pulse
    task automatic take(bit kind, logic [3:0] slot, logic [63:0] data);
        exp_t e;
        n_pulse++;
        if (q.size() == 0) begin
            check(1'b0, "R2", "unexpected pulse", data, 64'h0);
        end else begin
            e = q.pop_front();
            check(e.kind == kind && (kind || e.slot == slot) && e.data == data,
                  e.req, "pulse content", data, e.data);
            if (e.gap >= 0)
                check(cyc - last_cyc == e.gap, e.req, "pulse spacing",
                      64'(cyc - last_cyc), 64'(e.gap));
        end
        last_cyc = cyc;
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (disp_valid) take(1'b0, disp_slot, {32'b0, disp_word});
            if (act_valid)  take(1'b1, 4'd0, act_mask);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL R5 watchdog expired actual=%0d expected=0", q.size());
        finish_run();
    end

    int mark, k, held_pulses;
    logic [PC_W-1:0] frozen;

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;

        // R2 back to back dispatch
        emit_res(5, 24'h101, -1, "R2");
        emit_res(6, 24'h102, 1, "R2");
        emit_res(7, 24'h103, 1, "R2");
        // R4 timed waits
        put(w_wait(1'b0, 0));
        emit_res(7, 24'h104, 2, "R4");
        put(w_wait(1'b0, 5));
        emit_res(7, 24'h105, 7, "R4");
        // R6 R7 R8 activation
        emit_act(16'h0005, 0, 2, 64'h14, "R6");
        emit_act(16'h8000, 0, 60, 64'h0, "R6");
        emit_act(16'h0009, 1, 2, 64'h4004, "R7");
        emit_act(16'hFFFF, 1, 4, 64'h0, "R7");
        put(w_act(16'h0001, 3, 0));
        emit_res(8, 24'h106, 2, "R8");
        // R14 undefined control opcode
        put({1'b0, 3'd5, 28'h0123456});
        emit_res(8, 24'h107, 2, "R14");
        // R10 scalar arithmetic
        put(w_calc(1, 0, 0, 200, 1));
        chk_reg(1, 200, "R10");
        put(w_calc(1, 1, 0, 55, 2));   chk_reg(2, 255, "R10");
        put(w_calc(2, 1, 0, 50, 3));   chk_reg(3, 150, "R10");
        put(w_calc(2, 0, 0, 1, 4));
        put(w_calc(1, 4, 0, 2, 5));    chk_reg(5, 1, "R10");
        put(w_calc(1, 0, 0, 3, 7));
        put(w_calc(3, 7, 0, 4, 6));    chk_reg(6, 48, "R10");
        put(w_calc(4, 1, 0, 3, 8));    chk_reg(8, 25, "R10");
        put(w_calc(5, 7, 0, 21, 9));   chk_reg(9, 63, "R10");
        put(w_calc(8, 1, 0, 15, 10));  chk_reg(10, 8, "R10");
        put(w_calc(9, 7, 0, 48, 11));  chk_reg(11, 51, "R10");
        put(w_calc(10, 1, 0, 0, 12));
        put(w_calc(8, 12, 0, 255, 12)); chk_reg(12, 55, "R10");
        put(w_calc(11, 1, 0, 255, 13)); chk_reg(13, 55, "R10");
        // R9 register operand B
        put(w_calc(1, 1, 1, 7, 14));   chk_reg(14, 203, "R9");
        // R12 unsupported modes leave r14 alone
        put(w_calc(6, 1, 0, 1, 14));
        put(w_calc(0, 1, 0, 1, 14));
        put(w_calc(40, 1, 0, 1, 14));  chk_reg(14, 203, "R12");
        // R11 comparisons and flag logic
        put(w_calc(19, 1, 0, 100, 2));  chk_flag(2, 1'b1, "R11");
        put(w_calc(21, 1, 0, 100, 3));  chk_flag(3, 1'b0, "R11");
        put(w_calc(34, 3, 0, 0, 4));    chk_flag(4, 1'b1, "R11");
        put(w_calc(20, 1, 0, 200, 5));  chk_flag(5, 1'b1, "R11");
        put(w_calc(22, 7, 0, 2, 6));    chk_flag(6, 1'b0, "R11");
        put(w_calc(18, 1, 0, 200, 11)); chk_flag(11, 1'b0, "R11");
        put(w_calc(32, 2, 1, 5, 7));    chk_flag(7, 1'b1, "R11");
        put(w_calc(33, 3, 1, 6, 8));    chk_flag(8, 1'b0, "R11");
        put(w_calc(33, 3, 0, 1, 9));    chk_flag(9, 1'b1, "R9");
        // R13 backward loop, three passes
        emit_res(3, 24'h777, -1, "R13");
        put(w_calc(1, 15, 0, 1, 15));
        put(w_calc(18, 15, 0, 3, 10));
        put(w_brn(10, -3, 1));
        q.push_back('{1'b0, 4'd3, 64'(w_res(3, 24'h777)), 4, "R13"});
        q.push_back('{1'b0, 4'd3, 64'(w_res(3, 24'h777)), 4, "R13"});
        // R5 event wait, then R3 halt
        emit_res(4, 24'hE01, -1, "R5");
        mark = q.size();
        put(w_wait(1'b1, 1 << 3));
        emit_res(4, 24'hE02, -1, "R5");
        put(32'h0);

        evt_in = '0;
        rst_n  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(imem_addr == 0 && !disp_valid && !act_valid && !halted, "R1", "reset outputs",
              {imem_addr, disp_valid, act_valid, halted}, 64'h0);
        rst_n = 1'b1;

        wait (n_pulse == mark);
        evt_in = 27'(1 << 5);
        repeat (10) @(negedge clk);
        // R5 unselected event ignored
        check(n_pulse == mark, "R5", "pulses while waiting", 64'(n_pulse), 64'(mark));
        evt_in = 27'(1 << 3) | 27'(1 << 5);
        k = cyc;
        wait (n_pulse == mark + 1);
        // R5 release timing
        check(last_cyc == k + 2, "R5", "release cycle", 64'(last_cyc), 64'(k + 2));
        @(negedge clk);
        evt_in = '0;
        repeat (3) @(negedge clk);
        frozen = imem_addr;
        held_pulses = n_pulse;
        repeat (20) @(negedge clk);
        // R3 halt is final
        check(halted == 1'b1, "R3", "halted flag", 64'(halted), 64'h1);
        check(imem_addr == frozen, "R3", "frozen address", 64'(imem_addr), 64'(frozen));
        check(n_pulse == held_pulses, "R3", "pulses after halt", 64'(n_pulse), 64'(held_pulses));
        check(q.size() == 0, "R2", "items still expected", 64'(q.size()), 64'h0);
        finish_run();
    end

endmodule